// File: doc/BRIEF.md
# Interrupt Destination Dispatcher

This block hands one interrupt request at a time to a set of N CPU targets. A request carries a vector, a trigger mode, a delivery mode, the index of the input line that raised it, and a per-target destination-match vector. Each target has already compared its own address against the destination and reports the result in that vector. The dispatcher turns the request into registered one-cycle strobes. There are injection strobes, one per target, that carry a shared vector and trigger mode. There are NMI-set strobes and wake strobes for each target. A drop flag, with an added warning flag, marks requests whose mode is not supported.

The delivery mode decides the fan-out. Fixed mode reaches every matching target. Lowest-priority mode reaches exactly one target, chosen by a rotating pointer. NMI mode marks every matching target and wakes only those whose NMI was not already pending. A build-time override steers requests from input line 0 to target 0 while the timer channel is active. This keeps timer ticks on one CPU.

Top module: `intr_dispatch`

## Requirements
- R1: Delivery mode 3'b000 (fixed) raises `inj_strobe[i]` for every target i with `req_match[i]` set, in the cycle after acceptance. `inj_vector` and `inj_trig` hold the accepted request's values in that cycle. `drop` stays low, even when no target matches.
- R2: Delivery mode 3'b001 (lowest priority) raises exactly one `inj_strobe` bit. The search starts at the target after the one last chosen and wraps from N-1 to 0. It picks the first matching target. After reset the search starts at target 0.
- R3: A lowest-priority request with no matching target raises `drop` with no strobe and leaves `warn` low. The rotating pointer keeps its value.
- R4: Delivery mode 3'b100 (NMI) sets `nmi_set = req_match` and `nmi_wake = req_match & ~nmi_pending`. It raises no injection strobe.
- R5: Any other delivery-mode code raises both `drop` and `warn`. It raises no injection, NMI-set or wake strobe.
- R6: With the override enabled (parameter `PIN0_OVR`=1), a fixed or lowest-priority request goes to target 0 alone, whatever `req_match` holds, when `req_src` is 0 and `timer_active` is high. The rotating pointer keeps its value in that case. NMI requests ignore the override.
- R7: `req_ready` is low while reset is applied and high once it is released. It falls in the cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge) and rises again one cycle later.
- R8: Every strobe, `drop` and `warn` is low after reset and in every cycle that does not directly follow an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Dispatcher can accept a request |
| req_src | input | SRC_W | Index of the input line that raised the request |
| req_dmode | input | 3 | Delivery mode code |
| req_vector | input | VEC_W | Interrupt vector |
| req_trig | input | 1 | Trigger mode (1 = level) |
| req_match | input | N_TGT | Per-target destination match |
| nmi_pending | input | N_TGT | Per-target NMI-pending flags |
| timer_active | input | 1 | Timer channel 0 running |
| inj_strobe | output | N_TGT | Per-target injection strobe |
| inj_vector | output | VEC_W | Vector of the last accepted request |
| inj_trig | output | 1 | Trigger mode of the last accepted request |
| nmi_set | output | N_TGT | Per-target NMI-set strobe |
| nmi_wake | output | N_TGT | Per-target wake strobe |
| drop | output | 1 | Request discarded |
| warn | output | 1 | Request discarded for an unsupported mode |

## Verification
All results of a request come from one register stage, so they are due in the single cycle after the accepting edge. In the cycle after that, every strobe must be low and `req_ready` high again. The bench drives inputs on the falling edge and lets the accepting rising edge pass. It compares every output on the next falling edge against a model that tracks its own rotating pointer. It then checks the idle cycle on the falling edge that follows.

// File: rtl/intr_dispatch_pkg.sv
package intr_dispatch_pkg;
  localparam logic [2:0] DM_FIXED  = 3'b000;
  localparam logic [2:0] DM_LOWEST = 3'b001;
  localparam logic [2:0] DM_NMI    = 3'b100;
endpackage

// File: rtl/id_rr_select.sv
module id_rr_select #(
  parameter int N_TGT = 8,
  parameter int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic [N_TGT-1:0] match,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  // Walk offsets from far to near so the nearest match after 'last' wins.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = N_TGT - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(last) + 1 + k) % N_TGT;
      if (match[idx]) begin
        found = 1'b1;
        pick  = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/id_route.sv
module id_route
  import intr_dispatch_pkg::*;
#(
  parameter int N_TGT = 8,
  parameter int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic [2:0]       dmode,
  input  logic [N_TGT-1:0] match,
  input  logic [N_TGT-1:0] pend,
  input  logic             ovr,
  input  logic             lp_found,
  input  logic [IDX_W-1:0] lp_pick,
  output logic [N_TGT-1:0] inj,
  output logic [N_TGT-1:0] nset,
  output logic [N_TGT-1:0] wake,
  output logic             drop,
  output logic             warn,
  output logic             ptr_we
);
  localparam logic [N_TGT-1:0] ONE = {{(N_TGT-1){1'b0}}, 1'b1};

  always_comb begin
    inj    = '0;
    nset   = '0;
    wake   = '0;
    drop   = 1'b0;
    warn   = 1'b0;
    ptr_we = 1'b0;
    case (dmode)
      DM_FIXED: inj = ovr ? ONE : match;
      DM_LOWEST: begin
        if (ovr) begin
          inj = ONE;
        end else if (lp_found) begin
          inj    = ONE << lp_pick;
          ptr_we = 1'b1;
        end else begin
          drop = 1'b1;
        end
      end
      DM_NMI: begin
        nset = match;
        wake = match & ~pend;
      end
      default: begin
        drop = 1'b1;
        warn = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
  import intr_dispatch_pkg::*;
#(
  parameter int N_TGT    = 8,
  parameter int VEC_W    = 8,
  parameter int SRC_W    = 5,
  parameter bit PIN0_OVR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SRC_W-1:0] req_src,
  input  logic [2:0]       req_dmode,
  input  logic [VEC_W-1:0] req_vector,
  input  logic             req_trig,
  input  logic [N_TGT-1:0] req_match,
  input  logic [N_TGT-1:0] nmi_pending,
  input  logic             timer_active,
  output logic [N_TGT-1:0] inj_strobe,
  output logic [VEC_W-1:0] inj_vector,
  output logic             inj_trig,
  output logic [N_TGT-1:0] nmi_set,
  output logic [N_TGT-1:0] nmi_wake,
  output logic             drop,
  output logic             warn
);
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1;
  localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(N_TGT - 1);
  localparam logic [N_TGT-1:0] ONE = {{(N_TGT-1){1'b0}}, 1'b1};

  // Reset synchronizer: asserts at once, releases on the clock.
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic             ready_q, ready_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic [N_TGT-1:0] inj_q, inj_d, nset_q, nset_d, wake_q, wake_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             trig_q, trig_d, drop_q, drop_d, warn_q, warn_d;

  logic             accept, ovr, lp_found, ptr_we;
  logic [IDX_W-1:0] lp_pick;
  logic [N_TGT-1:0] r_inj, r_nset, r_wake;
  logic             r_drop, r_warn;

  assign req_ready = ready_q & rst_q;
  assign accept    = req_valid & req_ready;
  assign ovr       = PIN0_OVR & (req_src == '0) & timer_active;

  id_rr_select #(.N_TGT(N_TGT), .IDX_W(IDX_W)) u_sel (
    .match(req_match), .last(last_q), .found(lp_found), .pick(lp_pick)
  );

  id_route #(.N_TGT(N_TGT), .IDX_W(IDX_W)) u_route (
    .dmode(req_dmode), .match(req_match), .pend(nmi_pending), .ovr(ovr),
    .lp_found(lp_found), .lp_pick(lp_pick),
    .inj(r_inj), .nset(r_nset), .wake(r_wake),
    .drop(r_drop), .warn(r_warn), .ptr_we(ptr_we)
  );

  // Next state
  always_comb begin
    ready_d = 1'b1;
    last_d  = last_q;
    vec_d   = vec_q;
    trig_d  = trig_q;
    inj_d   = '0;
    nset_d  = '0;
    wake_d  = '0;
    drop_d  = 1'b0;
    warn_d  = 1'b0;
    if (accept) begin
      ready_d = 1'b0;
      vec_d   = req_vector;
      trig_d  = req_trig;
      inj_d   = r_inj;
      nset_d  = r_nset;
      wake_d  = r_wake;
      drop_d  = r_drop;
      warn_d  = r_warn;
      if (ptr_we) last_d = lp_pick;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ready_q <= 1'b1;
      last_q  <= LAST_RST;
      vec_q   <= '0;
      trig_q  <= 1'b0;
      inj_q   <= '0;
      nset_q  <= '0;
      wake_q  <= '0;
      drop_q  <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      ready_q <= ready_d;
      last_q  <= last_d;
      if (accept) begin
        vec_q  <= vec_d;
        trig_q <= trig_d;
      end
      inj_q  <= inj_d;
      nset_q <= nset_d;
      wake_q <= wake_d;
      drop_q <= drop_d;
      warn_q <= warn_d;
    end
  end

  assign inj_strobe = inj_q;
  assign inj_vector = vec_q;
  assign inj_trig   = trig_q;
  assign nmi_set    = nset_q;
  assign nmi_wake   = wake_q;
  assign drop       = drop_q;
  assign warn       = warn_q;

  // Assertions
  p_fixed_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && req_dmode == DM_FIXED && !ovr) |=>
      (inj_strobe == $past(req_match)) && !drop && (inj_vector == $past(req_vector)));

  p_lowest_one_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && req_dmode == DM_LOWEST) |=>
      ($countones(inj_strobe) <= 1) && (drop == (inj_strobe == '0)));

  p_lowest_drop_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && req_dmode == DM_LOWEST && req_match == '0 && !ovr) |=>
      drop && !warn && $stable(last_q));

  p_nmi_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && req_dmode == DM_NMI) |=>
      (nmi_set == $past(req_match)) &&
      (nmi_wake == ($past(req_match) & ~$past(nmi_pending))) && (inj_strobe == '0));

  p_unsup_r5: assert property (@(posedge clk) disable iff (!rst_q)
    warn |-> drop && (inj_strobe == '0) && (nmi_set == '0) && (nmi_wake == '0));

  p_override_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && ovr && (req_dmode == DM_FIXED || req_dmode == DM_LOWEST)) |=>
      (inj_strobe == ONE) && $stable(last_q));

  p_ready_fall_r7: assert property (@(posedge clk) disable iff (!rst_q)
    accept |=> !req_ready);

  p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !req_ready |=> req_ready);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !accept |=> (inj_strobe == '0) && (nmi_set == '0) && (nmi_wake == '0) && !drop && !warn);
endmodule

// File: tb/intr_dispatch_tb.sv
module intr_dispatch_tb;
  localparam int N = 8;
  localparam int VW = 8;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [SW-1:0] req_src = '0;
  logic [2:0] req_dmode = '0;
  logic [VW-1:0] req_vector = '0;
  logic req_trig = 1'b0;
  logic [N-1:0] req_match = '0;
  logic [N-1:0] nmi_pending = '0;
  logic timer_active = 1'b0;
  logic [N-1:0] inj_strobe, nmi_set, nmi_wake;
  logic [VW-1:0] inj_vector;
  logic inj_trig, drop, warn;

  int n_chk = 0;
  int n_bad = 0;
  int last_m = N - 1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intr_dispatch #(.N_TGT(N), .VEC_W(VW), .SRC_W(SW), .PIN0_OVR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dmode(req_dmode), .req_vector(req_vector),
    .req_trig(req_trig), .req_match(req_match), .nmi_pending(nmi_pending),
    .timer_active(timer_active), .inj_strobe(inj_strobe), .inj_vector(inj_vector),
    .inj_trig(inj_trig), .nmi_set(nmi_set), .nmi_wake(nmi_wake),
    .drop(drop), .warn(warn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model of the lowest-priority search; returns -1 when nothing matches.
  function automatic int lp_pick(input logic [N-1:0] m, input int last);
    for (int k = 0; k < N; k++) begin
      int idx = (last + 1 + k) % N;
      if (m[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic do_req(input logic [2:0] dm, input logic [N-1:0] m, input logic [N-1:0] pend,
                        input logic [VW-1:0] vec, input logic trig,
                        input logic [SW-1:0] src, input logic ten);
    logic [N-1:0] e_inj, e_set, e_wake;
    logic e_drop, e_warn, ovr;
    int p;
    e_inj = '0; e_set = '0; e_wake = '0; e_drop = 1'b0; e_warn = 1'b0;
    ovr = (src == '0) && ten;
    case (dm)
      3'b000: e_inj = ovr ? N'(1) : m;
      3'b001: begin
        if (ovr) e_inj = N'(1);
        else begin
          p = lp_pick(m, last_m);
          if (p < 0) e_drop = 1'b1;
          else begin e_inj = N'(1) << p; last_m = p; end
        end
      end
      3'b100: begin e_set = m; e_wake = m & ~pend; end
      default: begin e_drop = 1'b1; e_warn = 1'b1; end
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_dmode = dm; req_match = m; nmi_pending = pend;
    req_vector = vec; req_trig = trig; req_src = src; timer_active = ten;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1/R2/R6 inj_strobe", 32'(inj_strobe), 32'(e_inj));
    if (e_inj != '0) begin
      chk("R1 inj_vector", 32'(inj_vector), 32'(vec));
      chk("R1 inj_trig", 32'(inj_trig), 32'(trig));
    end
    chk("R4 nmi_set", 32'(nmi_set), 32'(e_set));
    chk("R4 nmi_wake", 32'(nmi_wake), 32'(e_wake));
    chk("R3/R5 drop", 32'(drop), 32'(e_drop));
    chk("R5 warn", 32'(warn), 32'(e_warn));
    chk("R7 ready low", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk("R8 idle strobes", 32'({inj_strobe, nmi_set, nmi_wake, drop, warn}), 32'd0);
    chk("R7 ready back", 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R7 ready in reset", 32'(req_ready), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 reset strobes", 32'({inj_strobe, nmi_set, nmi_wake, drop, warn}), 32'd0);
    chk("R7 ready after reset", 32'(req_ready), 32'd1);

    // R2 rotation with all targets matching: 0,1,2 then wrap at 7->0
    for (int i = 0; i < N + 2; i++) do_req(3'b001, '1, '0, 8'h30, 1'b1, 5'd3, 1'b0);
    // R2 sparse matches, search after last pick
    do_req(3'b001, 8'b1000_0101, '0, 8'h31, 1'b0, 5'd2, 1'b0);
    do_req(3'b001, 8'b1000_0101, '0, 8'h32, 1'b0, 5'd2, 1'b0);
    // R3 no match drops, pointer kept
    do_req(3'b001, '0, '0, 8'h33, 1'b0, 5'd2, 1'b1);
    do_req(3'b001, 8'b1000_0101, '0, 8'h34, 1'b0, 5'd2, 1'b0);
    // R1 fixed multicast and empty
    do_req(3'b000, 8'b0110_1001, '0, 8'h41, 1'b1, 5'd7, 1'b1);
    do_req(3'b000, '0, '0, 8'h42, 1'b0, 5'd7, 1'b0);
    // R6 override
    do_req(3'b000, 8'b1111_0000, '0, 8'h51, 1'b0, 5'd0, 1'b1);
    do_req(3'b001, 8'b1111_0000, '0, 8'h52, 1'b0, 5'd0, 1'b1);
    do_req(3'b001, 8'b1111_0000, '0, 8'h53, 1'b0, 5'd0, 1'b0);
    do_req(3'b100, 8'b0000_0110, '0, 8'h54, 1'b0, 5'd0, 1'b1);
    // R4 NMI with some already pending
    do_req(3'b100, 8'b1010_1010, 8'b1000_1000, 8'h02, 1'b0, 5'd4, 1'b0);
    // R5 unsupported codes
    do_req(3'b111, '1, '0, 8'h60, 1'b1, 5'd1, 1'b0);
    do_req(3'b010, '1, '0, 8'h61, 1'b0, 5'd0, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] dm;
      int r = $urandom % 8;
      if (r < 2) dm = 3'b000;
      else if (r < 4) dm = 3'b001;
      else if (r < 6) dm = 3'b100;
      else dm = 3'($urandom);
      do_req(dm, N'($urandom), N'($urandom), VW'($urandom), 1'($urandom),
             SW'($urandom % 4), 1'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule